// File: doc/BRIEF.md
# Fractional rate pacing timer

This block produces a stream of single-cycle transfer-request pulses whose long-run rate is a programmable fraction X/Y of the clock. A downstream transfer engine can use it to pace data movement at a rate that is not an integer division of the clock. For example, X=3 and Y=8 gives three requests in every eight cycles, spread as evenly as the cycle grid allows.

Software programs the fraction with one 32-bit word through a write strobe. The numerator sits in the upper half of the word and the denominator in the lower half. Internally, a remainder accumulator gains X on every cycle. The block issues a request each time the accumulator reaches Y, and then removes Y from it. A fraction of one or more requests on every cycle. A zero in either half turns the output off.

Top module: `frac_pace_timer`

## Requirements
- R1: While reset is asserted, and after its release with no write, `treq` stays low; the configuration word resets to zero.
- R2: The numerator X is taken from `cfg_wdata[31:16]` and the denominator Y from `cfg_wdata[15:0]`, each an unsigned 16-bit value.
- R3: With X equal to Y (both nonzero), `treq` is high on every cycle from the first evaluation after a write.
- R4: With X or Y equal to zero, `treq` is never asserted.
- R5: With X greater than Y, `treq` is high on every cycle and the accumulator holds its value instead of growing.
- R6: With 0 < X < Y, the n-th evaluation after a write asserts `treq` exactly when floor(n·X/Y) exceeds floor((n−1)·X/Y); the accumulator stays below Y.
- R7: In the first Y evaluations after a write with X ≤ Y, exactly X pulses are produced.
- R8: The cycle after a write edge shows `treq` low, and the accumulator restarts from zero, so a repeated write restarts the pulse pattern.
- R9: At most one pulse is produced per cycle; the first evaluation of a new word is the clock edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Packed {X, Y} configuration word |
| treq | output | 1 | Registered single-cycle transfer-request pulse |

## Verification
A write is taken at clock edge k. The configuration and the cleared accumulator are visible just after edge k, and `treq` is low in that cycle. The n-th evaluation of the new fraction drives `treq` just after edge k+n, because the output register is the only stage between the accumulator and the pin. The bench drives every input on the falling edge and samples `treq` on the falling edge that follows each rising edge. Each sample lines up with exactly one evaluation index n, and the expected value for that n comes from the floor formula or from the per-window pulse count. The first internal stage has a two-flop reset synchronizer, so the bench waits several cycles after the reset release before it makes its first write.

// File: rtl/frac_pace_pkg.sv
package frac_pace_pkg;

  localparam int unsigned FP_NUM_W = 16;

  // Operating class of the programmed fraction
  typedef enum logic [1:0] {
    PACE_OFF  = 2'd0,   // numerator or denominator zero
    PACE_FULL = 2'd1,   // numerator >= denominator: request every cycle
    PACE_FRAC = 2'd2    // proper fraction: accumulate and compare
  } pace_mode_e;

endpackage

// File: rtl/frac_pace_rst_sync.sv
module frac_pace_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/frac_pace_cfg.sv
module frac_pace_cfg #(
  parameter int unsigned CFG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             restart_o
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             cfg_en;

  always_comb begin
    cfg_en = we_i;
    cfg_d  = we_i ? wdata_i : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign restart_o = we_i;

  // R2: a strobed word is the one held after the edge
  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cfg_q == $past(wdata_i)));

  // R1: no strobe, no change
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_q));

endmodule

// File: rtl/frac_pace_decode.sv
module frac_pace_decode
  import frac_pace_pkg::*;
#(
  parameter int unsigned NUM_W = FP_NUM_W,
  localparam int unsigned CFG_W = 2 * NUM_W
) (
  input  logic [CFG_W-1:0] cfg_i,
  output logic [NUM_W-1:0] x_o,
  output logic [NUM_W-1:0] y_o,
  output pace_mode_e       mode_o
);

  // Numerator occupies the upper half, denominator the lower half
  always_comb begin
    x_o = cfg_i[CFG_W-1:NUM_W];
    y_o = cfg_i[NUM_W-1:0];
    if ((x_o == '0) || (y_o == '0)) mode_o = PACE_OFF;
    else if (x_o >= y_o)            mode_o = PACE_FULL;
    else                            mode_o = PACE_FRAC;
  end

endmodule

// File: rtl/frac_pace_accum.sv
module frac_pace_accum
  import frac_pace_pkg::*;
#(
  parameter int unsigned NUM_W = FP_NUM_W,
  localparam int unsigned SUM_W = NUM_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  pace_mode_e       mode_i,
  input  logic [NUM_W-1:0] x_i,
  input  logic [NUM_W-1:0] y_i,
  output logic             treq_o
);

  logic [NUM_W-1:0] acc_q, acc_d;
  logic             acc_en;
  logic             treq_q, treq_d;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, x_i};
    rem    = sum - {1'b0, y_i};
    acc_d  = acc_q;
    treq_d = 1'b0;
    acc_en = 1'b0;
    if (clr_i) begin
      acc_d  = '0;
      acc_en = 1'b1;
    end else begin
      unique case (mode_i)
        PACE_OFF: begin
          acc_d  = '0;
          acc_en = (acc_q != '0);
        end
        PACE_FULL: begin
          treq_d = 1'b1;            // accumulator frozen
        end
        PACE_FRAC: begin
          acc_en = 1'b1;
          if (sum >= {1'b0, y_i}) begin
            acc_d  = rem[NUM_W-1:0];
            treq_d = 1'b1;
          end else begin
            acc_d  = sum[NUM_W-1:0];
          end
        end
        default: begin
          acc_d  = '0;
          acc_en = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) treq_q <= 1'b0;
    else        treq_q <= treq_d;
  end

  assign treq_o = treq_q;

  // R6: remainder never reaches the denominator in fraction mode
  p_acc_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PACE_FRAC) |-> (acc_q < y_i));

  // R5: over-unity fraction freezes the accumulator
  p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PACE_FULL && !clr_i) |=> $stable(acc_q));

  // R8: a restart leaves the accumulator empty
  p_clr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

endmodule

// File: rtl/frac_pace_timer.sv
module frac_pace_timer
  import frac_pace_pkg::*;
#(
  parameter int unsigned NUM_W      = FP_NUM_W,
  parameter int unsigned RST_STAGES = 2,
  localparam int unsigned CFG_W     = 2 * NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             treq
);

  logic             rst_sync_n;
  logic [CFG_W-1:0] cfg_word;
  logic             restart;
  logic [NUM_W-1:0] num_x;
  logic [NUM_W-1:0] den_y;
  pace_mode_e       mode;

  frac_pace_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  frac_pace_cfg #(.CFG_W(CFG_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (cfg_we),
    .wdata_i   (cfg_wdata),
    .cfg_o     (cfg_word),
    .restart_o (restart)
  );

  frac_pace_decode #(.NUM_W(NUM_W)) u_decode (
    .cfg_i  (cfg_word),
    .x_o    (num_x),
    .y_o    (den_y),
    .mode_o (mode)
  );

  frac_pace_accum #(.NUM_W(NUM_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (restart),
    .mode_i (mode),
    .x_i    (num_x),
    .y_i    (den_y),
    .treq_o (treq)
  );

  // R8: the cycle after a write edge is quiet
  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> !treq);

  // R4: zero numerator or denominator silences the output
  p_off_silent_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_we && mode == PACE_OFF) |=> !treq);

  // R3: unity or larger fraction requests every cycle
  p_full_every_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_we && mode == PACE_FULL) |=> treq);

  // R1: output low while reset is held
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_sync_n |-> !treq);

endmodule

// File: tb/frac_pace_timer_bench.sv
module frac_pace_timer_bench;

  localparam time CLK_PERIOD      = 10ns;
  localparam int  WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic        treq;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_pace_timer u_frac_pace_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .treq      (treq)
  );

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Write at the next edge; returns on the falling edge after it (R8, R9)
  task automatic write_cfg(logic [15:0] x, logic [15:0] y);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = {x, y};
    @(posedge clk);
    @(negedge clk);
    cfg_we    = 1'b0;
    check_bit("R8", "treq in cycle after write", treq, 1'b0);
  endtask

  function automatic logic expect_pulse(longint x, longint y, longint n);
    if (y == 0 || x == 0) return 1'b0;
    return ((n * x) / y) > (((n - 1) * x) / y);
  endfunction

  task automatic run_pattern(string req, logic [15:0] x, logic [15:0] y, int cycles);
    for (int n = 1; n <= cycles; n++) begin
      step();
      check_bit(req, $sformatf("x=%0d y=%0d n=%0d", x, y, n), treq,
                expect_pulse(longint'(x), longint'(y), longint'(n)));
    end
  endtask

  task automatic run_window(string req, logic [15:0] x, logic [15:0] y);
    longint cnt = 0;
    for (int n = 1; n <= int'(y); n++) begin
      step();
      if (treq === 1'b1) cnt++;
    end
    check_int(req, $sformatf("pulses in window x=%0d y=%0d", x, y), cnt, longint'(x));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit("R1", "treq during reset", treq, 1'b0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      step();
      check_bit("R1", "treq after reset, no write", treq, 1'b0);
    end
  endtask

  task automatic t_fields();
    write_cfg(16'd1, 16'd3);
    run_pattern("R2", 16'd1, 16'd3, 12);
    write_cfg(16'd3, 16'd1);
    run_pattern("R2", 16'd3, 16'd1, 6);
  endtask

  task automatic t_equal();
    write_cfg(16'd5, 16'd5);
    for (int n = 1; n <= 10; n++) begin
      step();
      check_bit("R3", $sformatf("x=y n=%0d", n), treq, 1'b1);
    end
  endtask

  task automatic t_zero();
    write_cfg(16'd3, 16'd4);
    run_pattern("R6", 16'd3, 16'd4, 5);
    write_cfg(16'd0, 16'd7);
    for (int n = 1; n <= 20; n++) begin
      step();
      check_bit("R4", "x=0", treq, 1'b0);
    end
    write_cfg(16'd9, 16'd0);
    for (int n = 1; n <= 20; n++) begin
      step();
      check_bit("R4", "y=0", treq, 1'b0);
    end
    write_cfg(16'd0, 16'd0);
    for (int n = 1; n <= 8; n++) begin
      step();
      check_bit("R4", "x=y=0", treq, 1'b0);
    end
  endtask

  task automatic t_over();
    write_cfg(16'd200, 16'd7);
    for (int n = 1; n <= 40; n++) begin
      step();
      check_bit("R5", $sformatf("x>y n=%0d", n), treq, 1'b1);
    end
    // after a long over-unity run, a proper fraction starts clean
    write_cfg(16'd2, 16'd9);
    run_pattern("R5", 16'd2, 16'd9, 18);
  endtask

  task automatic t_pattern();
    write_cfg(16'd3, 16'd8);
    run_pattern("R6", 16'd3, 16'd8, 32);
    write_cfg(16'd7, 16'd10);
    run_pattern("R6", 16'd7, 16'd10, 30);
    write_cfg(16'd1, 16'd2);
    run_pattern("R9", 16'd1, 16'd2, 8);
  endtask

  task automatic t_window();
    write_cfg(16'd7, 16'd10);
    run_window("R7", 16'd7, 16'd10);
    write_cfg(16'd333, 16'd1000);
    run_window("R7", 16'd333, 16'd1000);
    write_cfg(16'd65534, 16'd65535);
    run_window("R7", 16'd65534, 16'd65535);
    write_cfg(16'd1, 16'd40000);
    run_window("R7", 16'd1, 16'd40000);
  endtask

  task automatic t_restart();
    write_cfg(16'd2, 16'd7);
    run_pattern("R8", 16'd2, 16'd7, 4);
    write_cfg(16'd2, 16'd7);
    run_pattern("R8", 16'd2, 16'd7, 14);
  endtask

  task automatic t_extreme();
    write_cfg(16'd65535, 16'd65534);
    for (int n = 1; n <= 16; n++) begin
      step();
      check_bit("R5", "x=65535 y=65534", treq, 1'b1);
    end
    write_cfg(16'd65535, 16'd65535);
    for (int n = 1; n <= 8; n++) begin
      step();
      check_bit("R3", "x=y=65535", treq, 1'b1);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fields();
    t_equal();
    t_zero();
    t_over();
    t_pattern();
    t_restart();
    t_extreme();
    t_window();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule